// File: doc/BRIEF.md
# Dual-Half Receive Word Buffer

This block sits between a serial-bus receiver and a host processor with a 16-bit data bus. The receiver hands over each complete 32-bit word with a one-cycle valid strobe. The block stores up to 32 such words in arrival order. The host fetches each word as two 16-bit halves: first the lower half, then the upper half. The host selects the half with a select input and fetches it with a one-cycle read enable. A word leaves the buffer only when its upper half is read.

Three active-low flags report the buffer state: data ready, half full and full. The host can use the half-full flag as an interrupt to read a block of sixteen words in one pass. If the host falls behind and a word arrives while all 32 places are taken, the new word replaces the most recently stored word. The older words are kept and the count does not change.

Top module: `rxhalf_buffer`

## Requirements
- R1: After reset `rdData` is 0, the word count is 0, and `readyN`, `halfFullN` and `fullN` are all 1.
- R2: When `wordValid` is 1 at a clock edge and the buffer is not full, `wordIn` is stored behind the existing words. `readyN` reads 0 from that same edge.
- R3: When `rdEn` is 1 at an edge and the buffer holds a word, `rdData` shows a half of the oldest word from that edge on. With `halfSel` at 0 it shows bits 15:0, and with `halfSel` at 1 it shows bits 31:16. Words come out in arrival order.
- R4: A read with `halfSel` at 0 does not remove the word. Repeated lower-half reads return the same value, and no flag changes.
- R5: A read with `halfSel` at 1 removes the oldest word. `readyN` returns to 1 at the edge that removes the last stored word, and not before.
- R6: `halfFullN` is 0 exactly when 16 or more words are stored. It updates at the edge that changes the count.
- R7: `fullN` is 0 exactly when 32 words are stored. It updates at the edge that changes the count.
- R8: When `wordValid` is 1 while 32 words are stored and no word is removed at that edge, the new word replaces the newest stored word. The count stays at 32, and the older words are unchanged.
- R9: A read while the buffer is empty leaves `rdData` at its previous value and changes no flag or count. When `rdEn` is 0, `rdData` holds its value.
- R10: When a word arrives at the same edge that an upper-half read removes a word from a full buffer, the new word is appended normally. The count stays at 32 and nothing is overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | One-cycle strobe: a received word is on `wordIn` |
| wordIn | input | 32 | Received word from the deserializer |
| rdEn | input | 1 | One-cycle host read strobe |
| halfSel | input | 1 | Half select: 0 for bits 15:0, 1 for bits 31:16 (the upper-half read removes the word) |
| rdData | output | 16 | Registered host read bus |
| readyN | output | 1 | Data ready, active low: at least one word is stored |
| halfFullN | output | 1 | Half full, active low: 16 or more words are stored |
| fullN | output | 1 | Full, active low: 32 words are stored |

## Verification
The bench builds the block with its default parameters: a depth of 32 words, a width of 32 bits and a half-full mark of 16. With these values both flag thresholds and the overwrite of the newest entry are reached after a few dozen writes. The bench fills the buffer to exactly 15, 16, 31 and 32 words to check the flag edges. It then forces an overwrite and an arrival at the same edge as a removal while full, and drains the buffer against a model queue. This shows that the replaced word is the newest one and that the arrival order survives both cases.

// File: rtl/rxhalf_pkg.sv
package rxhalf_pkg;

  // Strobes the control sends to the storage datapath each cycle
  typedef struct packed {
    logic push;       // append a word at the tail
    logic overwrite;  // replace the newest stored word
    logic loadLow;    // drive lower half of the head word onto the bus
    logic loadHigh;   // drive upper half of the head word onto the bus
  } fifoStrobes_t;

endpackage

// File: rtl/rxhalf_ctrl.sv
module rxhalf_ctrl
  import rxhalf_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int HALF_MARK = DEPTH / 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wordValid,
  input  logic          rdEn,
  input  logic          halfSel,
  output fifoStrobes_t  strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          readyN,
  output logic          halfFullN,
  output logic          fullN
);

  logic [CW-1:0] count;
  logic [CW-1:0] nextCount;
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic          isEmpty;
  logic          isFull;
  logic          popWord;

  assign isEmpty = (count == '0);
  assign isFull  = (count == CW'(DEPTH));

  // An upper-half read is the only thing that retires a word
  assign popWord = rdEn && halfSel && !isEmpty;

  always_comb begin
    strobes           = '0;
    strobes.loadLow   = rdEn && !halfSel && !isEmpty;
    strobes.loadHigh  = popWord;
    // A freed slot at this edge lets a full buffer accept a normal append
    strobes.push      = wordValid && (!isFull || popWord);
    strobes.overwrite = wordValid && isFull && !popWord;
  end

  assign wrAddr = strobes.overwrite ? (wrPtr - AW'(1)) : wrPtr;
  assign rdAddr = rdPtr;

  always_comb begin
    nextCount = count;
    if (strobes.push && !popWord)
      nextCount = count + CW'(1);
    else if (!strobes.push && popWord)
      nextCount = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      readyN    <= 1'b1;
      halfFullN <= 1'b1;
      fullN     <= 1'b1;
    end else begin
      count <= nextCount;
      if (strobes.push)
        wrPtr <= wrPtr + AW'(1);
      if (popWord)
        rdPtr <= rdPtr + AW'(1);
      readyN    <= (nextCount == '0);
      halfFullN <= !(nextCount >= CW'(HALF_MARK));
      fullN     <= !(nextCount == CW'(DEPTH));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)) else $error("count above depth"); // R7

  AST_FULL_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && isFull && !(rdEn && halfSel)) |=> (isFull && !fullN && $stable(wrPtr)))
    else $error("overwrite changed count"); // R8

  AST_LOW_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !halfSel && !wordValid) |=> ($stable(count) && $stable(rdPtr)))
    else $error("lower-half read popped"); // R4

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && isEmpty && !wordValid) |=> (isEmpty && readyN && $stable(rdPtr)))
    else $error("empty read changed state"); // R9

  AST_READY_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (popWord && !wordValid && count == CW'(1)) |=> (readyN && isEmpty))
    else $error("ready not released on last pop"); // R5

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && isFull && popWord) |=> (isFull && !fullN && $changed(rdPtr)))
    else $error("arrival with pop at full mishandled"); // R10

endmodule

// File: rtl/rxhalf_store.sv
module rxhalf_store
  import rxhalf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int WORD_W   = 32,
  localparam int AW      = $clog2(DEPTH),
  localparam int HALF_W  = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [WORD_W-1:0] wordIn,
  output logic [HALF_W-1:0] rdData
);

  logic [WORD_W-1:0] slots [DEPTH];
  logic [WORD_W-1:0] headWord;

  assign headWord = slots[rdAddr];

  always_ff @(posedge clk) begin
    if (strobes.push || strobes.overwrite)
      slots[wrAddr] <= wordIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (strobes.loadLow)
      rdData <= headWord[HALF_W-1:0];
    else if (strobes.loadHigh)
      rdData <= headWord[WORD_W-1:HALF_W];
  end

  AST_ONE_HALF: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadLow && strobes.loadHigh)) else $error("two halves at once"); // R3

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.push && strobes.overwrite)) else $error("push and overwrite together"); // R8

endmodule

// File: rtl/rxhalf_buffer.sv
module rxhalf_buffer
  import rxhalf_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int WORD_W    = 32,
  parameter int HALF_MARK = DEPTH / 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int HALF_W   = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              rdEn,
  input  logic              halfSel,
  output logic [HALF_W-1:0] rdData,
  output logic              readyN,
  output logic              halfFullN,
  output logic              fullN
);

  fifoStrobes_t  strobes;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  rxhalf_ctrl #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .rdEn      (rdEn),
    .halfSel   (halfSel),
    .strobes   (strobes),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .readyN    (readyN),
    .halfFullN (halfFullN),
    .fullN     (fullN)
  );

  rxhalf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) storeInst (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wordIn  (wordIn),
    .rdData  (rdData)
  );

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)) else $error("bus moved without read"); // R9

  AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (!fullN |-> !halfFullN) and (!halfFullN |-> !readyN))
    else $error("flag ordering broken"); // R6

endmodule

// File: tb/rxhalf_buffer_test.sv
module rxhalf_buffer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordIn = '0;
  logic        rdEn = 1'b0;
  logic        halfSel = 1'b0;
  logic [15:0] rdData;
  logic        readyN;
  logic        halfFullN;
  logic        fullN;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model[$];

  always #2 clk = ~clk;

  rxhalf_buffer uut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .rdEn(rdEn), .halfSel(halfSel), .rdData(rdData),
    .readyN(readyN), .halfFullN(halfFullN), .fullN(fullN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input int i);
    return {16'hA000 + 16'(i), 16'h5000 + 16'(i)};
  endfunction

  // Inputs change on falling edges; results sampled on the next falling edge
  task automatic putWord(input logic [31:0] w);
    wordValid = 1'b1; wordIn = w;
    @(negedge clk);
    wordValid = 1'b0;
    if (model.size() < 32) model.push_back(w);
    else model[model.size()-1] = w;
  endtask

  task automatic readHalf(input logic sel);
    rdEn = 1'b1; halfSel = sel;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkFlags(input string req);
    check(req, {31'd0, readyN},    {31'd0, model.size() == 0});
    check(req, {31'd0, halfFullN}, {31'd0, !(model.size() >= 16)});
    check(req, {31'd0, fullN},     {31'd0, !(model.size() == 32)});
  endtask

  task automatic drainOne(input string req);
    logic [31:0] exp;
    exp = model[0];
    readHalf(1'b0);
    check(req, {16'd0, rdData}, {16'd0, exp[15:0]});
    readHalf(1'b1);
    void'(model.pop_front());
    check(req, {16'd0, rdData}, {16'd0, exp[31:16]});
    checkFlags(req);
  endtask

  task automatic testReset();
    check("R1 rdData", {16'd0, rdData}, 32'd0);
    check("R1 readyN", {31'd0, readyN}, 32'd1);
    check("R1 halfFullN", {31'd0, halfFullN}, 32'd1);
    check("R1 fullN", {31'd0, fullN}, 32'd1);
  endtask

  task automatic testEmptyRead();
    readHalf(1'b0);
    check("R9 empty low read bus", {16'd0, rdData}, 32'd0);
    readHalf(1'b1);
    check("R9 empty high read bus", {16'd0, rdData}, 32'd0);
    checkFlags("R9 empty read flags");
  endtask

  task automatic testSingleWord();
    putWord(32'hBEEF_1234);
    check("R2 readyN after write", {31'd0, readyN}, 32'd0);
    readHalf(1'b0);
    check("R3 lower half", {16'd0, rdData}, 32'h1234);
    readHalf(1'b0);
    check("R4 lower half repeat", {16'd0, rdData}, 32'h1234);
    check("R4 readyN kept", {31'd0, readyN}, 32'd0);
    readHalf(1'b1);
    void'(model.pop_front());
    check("R3 upper half", {16'd0, rdData}, 32'hBEEF);
    check("R5 readyN released", {31'd0, readyN}, 32'd1);
    readHalf(1'b0);
    check("R9 read after drain keeps bus", {16'd0, rdData}, 32'hBEEF);
  endtask

  task automatic testFillAndOverwrite();
    for (int i = 0; i < 15; i++) putWord(mkWord(i));
    checkFlags("R6 at 15");
    putWord(mkWord(15));
    checkFlags("R6 at 16");
    for (int i = 16; i < 31; i++) putWord(mkWord(i));
    checkFlags("R7 at 31");
    putWord(mkWord(31));
    checkFlags("R7 at 32");
    putWord(32'hC0DE_F00D);
    checkFlags("R8 count held at 32");
    // Drain all: order intact, last word is the replacement
    for (int i = 0; i < 31; i++) drainOne("R3 R8 drain");
    check("R8 newest replaced", model[0], 32'hC0DE_F00D);
    check("R5 ready before last", {31'd0, readyN}, 32'd0);
    drainOne("R5 R8 last word");
  endtask

  task automatic testArriveWithPop();
    for (int i = 0; i < 32; i++) putWord(mkWord(100 + i));
    checkFlags("R10 prefill");
    // Arrival and upper-half pop at the same edge
    wordValid = 1'b1; wordIn = 32'h7777_8888;
    rdEn = 1'b1; halfSel = 1'b1;
    @(negedge clk);
    wordValid = 1'b0; rdEn = 1'b0;
    check("R10 popped head upper", {16'd0, rdData}, {16'd0, model[0][31:16]});
    void'(model.pop_front());
    model.push_back(32'h7777_8888);
    checkFlags("R10 still full");
    for (int i = 0; i < 32; i++) drainOne("R10 drain");
    checkFlags("R10 empty at end");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEmptyRead();
    testSingleWord();
    testFillAndOverwrite();
    testArriveWithPop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule